// File: doc/BRIEF.md
# Associative Jump Trace Predictor

This block is a small fully associative store that remembers where recently taken control transfers went. Each of its entries pairs a key, the address of the last parcel of a transfer instruction, with the address that the transfer jumped to. Each entry also has a use bit that marks it as valid. The instruction pre-fetch logic presents every address it generates on the lookup port. On a hit it receives the remembered target in the same cycle and can begin fetching the new sequence at once.

The store is trained from the execution side. When a taken transfer was not predicted and its target came from a literal operand, the executing unit supplies two addresses. One is the fall-through address, which is the first parcel after the transfer. The other is the target. The store decrements the fall-through address to form the key and writes the pair into the entry chosen by a round-robin pointer. A predicted transfer that turns out not to be taken leaves the store untouched. A clear input, raised on a process change, empties the whole store.

Top module: `jump_trace_store`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the replacement pointer selects entry 0.
- R2: In the same cycle as the lookup, `lk_hit_o` is 1 exactly when `lk_addr_i` equals the key of a valid entry, and `lk_target_o` carries that entry's target. On a miss `lk_target_o` is all zeros.
- R3: An entry is written only when `upd_valid_i`, `upd_taken_i` and `upd_literal_i` are all 1 and `upd_predicted_i` is 0. Any other update leaves the store unchanged.
- R4: The stored key is `upd_next_addr_i` minus one, modulo 2^ADDR_W. A fall-through address of 0 gives a key of all ones.
- R5: Writes go to entries 0, 1, ... ENTRIES-1 in turn and then wrap back to 0. The write that follows ENTRIES writes therefore replaces the oldest entry, and that entry's key then misses.
- R6: When `clear_i` is 1, every entry becomes invalid and the pointer returns to entry 0 at the next edge. An update presented in the same cycle is discarded.
- R7: When a write uses a key that is already held by another valid entry, that older entry is invalidated. A lookup of the key then returns the new target, and no lookup ever matches more than one entry.
- R8: A lookup in the cycle in which an update to the same key is presented returns the contents from before the update. The new pair becomes visible in the following cycle.
- R9: An update that carries `upd_predicted_i` = 1 (a predicted transfer, whether or not it was taken) does not modify or invalidate any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Invalidate all entries and reset the pointer (process change) |
| lk_addr_i | input | ADDR_W | Address presented for lookup |
| lk_hit_o | output | 1 | Lookup matched a valid entry |
| lk_target_o | output | ADDR_W | Target of the matching entry, zero on a miss |
| upd_valid_i | input | 1 | A resolved transfer is being reported |
| upd_taken_i | input | 1 | The reported transfer jumped |
| upd_predicted_i | input | 1 | The reported transfer had been predicted by this store |
| upd_literal_i | input | 1 | The transfer's target came from a literal operand |
| upd_next_addr_i | input | ADDR_W | Fall-through address (first parcel after the transfer) |
| upd_target_addr_i | input | ADDR_W | Target address of the transfer |

## Verification
Some properties are checked by the assertions on every cycle. At most one entry matches any lookup. No entry becomes valid unless a qualified write took place. The store is empty after a clear. The pointer advances by exactly one entry, with wrap-around, on each write. A hit is only possible while some entry is valid. Other behaviours can only be shown by the bench's scenarios, which compare lookups against an independent model. These are the actual key and target values: the decrement with its wrap at zero, the eviction order after the store fills, the replacement of a duplicate key, and the rule that a lookup in the same cycle as an update sees the old contents.

// File: rtl/jt_pkg.sv
package jt_pkg;
  localparam int JT_ENTRIES_DEF = 8;
  localparam int JT_ADDR_W_DEF  = 16;

  // Advance a round-robin index with wrap at n entries.
  function automatic int jt_ptr_next(input int cur, input int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/jt_entry.sv
module jt_entry #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr,
  input  logic              kill,
  input  logic [ADDR_W-1:0] key_in,
  input  logic [ADDR_W-1:0] tgt_in,
  output logic              used,
  output logic [ADDR_W-1:0] key,
  output logic [ADDR_W-1:0] tgt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= 1'b0;
      key  <= '0;
      tgt  <= '0;
    end else if (clear) begin
      used <= 1'b0;
    end else if (wr) begin
      used <= 1'b1;
      key  <= key_in;
      tgt  <= tgt_in;
    end else if (kill) begin
      used <= 1'b0;
    end
  end
endmodule

// File: rtl/jt_alloc.sv
module jt_alloc #(
  parameter int ENTRIES = 8,
  localparam int PW = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               adv,
  output logic [PW-1:0]      ptr,
  output logic [ENTRIES-1:0] sel
);
  import jt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (clear)  ptr <= '0;
    else if (adv)    ptr <= PW'(jt_ptr_next(int'(ptr), ENTRIES));
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
    assign sel[i] = (ptr == PW'(i));
  end
endmodule

// File: rtl/jt_match.sv
module jt_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [ENTRIES-1:0]             used,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] keys,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tgts,
  output logic [ENTRIES-1:0]             match,
  output logic                           hit,
  output logic [ADDR_W-1:0]              target
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = used[i] && (keys[i] == addr);
  end

  assign hit = |match;

  // Keys are kept unique, so an OR of the masked targets acts as a mux.
  always_comb begin
    target = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      target = target | (tgts[i] & {ADDR_W{match[i]}});
    end
  end
endmodule

// File: rtl/jump_trace_store.sv
module jump_trace_store #(
  parameter int ENTRIES = jt_pkg::JT_ENTRIES_DEF,
  parameter int ADDR_W  = jt_pkg::JT_ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [ADDR_W-1:0] lk_target_o,
  input  logic              upd_valid_i,
  input  logic              upd_taken_i,
  input  logic              upd_predicted_i,
  input  logic              upd_literal_i,
  input  logic [ADDR_W-1:0] upd_next_addr_i,
  input  logic [ADDR_W-1:0] upd_target_addr_i
);
  localparam int PW = $clog2(ENTRIES);

  // Key of a transfer: the parcel just before the fall-through address.
  function automatic logic [ADDR_W-1:0] from_key(input logic [ADDR_W-1:0] next_addr);
    return next_addr - ADDR_W'(1);
  endfunction

  logic [ENTRIES-1:0]             valid_vec;
  logic [ENTRIES-1:0][ADDR_W-1:0] key_arr;
  logic [ENTRIES-1:0][ADDR_W-1:0] tgt_arr;
  logic [ENTRIES-1:0]             match_vec;
  logic [ENTRIES-1:0]             sel_vec;
  logic [ENTRIES-1:0]             dup_vec;
  logic [PW-1:0]                  wr_ptr;
  logic                           wr_en;
  logic [ADDR_W-1:0]              wr_key;

  assign wr_en  = upd_valid_i && upd_taken_i && !upd_predicted_i
                  && upd_literal_i && !clear_i;
  assign wr_key = from_key(upd_next_addr_i);

  jt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear_i),
    .adv   (wr_en),
    .ptr   (wr_ptr),
    .sel   (sel_vec)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign dup_vec[i] = valid_vec[i] && (key_arr[i] == wr_key) && !sel_vec[i];

    jt_entry #(.ADDR_W(ADDR_W)) u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clear_i),
      .wr     (wr_en && sel_vec[i]),
      .kill   (wr_en && dup_vec[i]),
      .key_in (wr_key),
      .tgt_in (upd_target_addr_i),
      .used   (valid_vec[i]),
      .key    (key_arr[i]),
      .tgt    (tgt_arr[i])
    );
  end

  jt_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .addr   (lk_addr_i),
    .used   (valid_vec),
    .keys   (key_arr),
    .tgts   (tgt_arr),
    .match  (match_vec),
    .hit    (lk_hit_o),
    .target (lk_target_o)
  );
endmodule

// File: rtl/jt_chk.sv
module jt_chk #(
  parameter int ENTRIES = 8,
  parameter int PW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clear_i,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               wr_en,
  input logic [PW-1:0]      wr_ptr,
  input logic               lk_hit
);
  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (valid_vec == '0 && wr_ptr == '0));

  // R3
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((valid_vec & ~$past(valid_vec)) == '0));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_ptr == (($past(wr_ptr) == PW'(ENTRIES - 1)) ? '0 : $past(wr_ptr) + PW'(1))));

  // R2
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ($countones(valid_vec) > 0));
endmodule

bind jump_trace_store jt_chk #(.ENTRIES(ENTRIES), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear_i   (clear_i),
  .match_vec (match_vec),
  .valid_vec (valid_vec),
  .wr_en     (wr_en),
  .wr_ptr    (wr_ptr),
  .lk_hit    (lk_hit_o)
);

// File: tb/sim_jump_trace_store.sv
module sim_jump_trace_store;
  localparam int N  = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear_i = 1'b0;
  logic [AW-1:0] lk_addr_i = '0;
  logic          lk_hit_o;
  logic [AW-1:0] lk_target_o;
  logic          upd_valid_i = 1'b0, upd_taken_i = 1'b0;
  logic          upd_predicted_i = 1'b0, upd_literal_i = 1'b0;
  logic [AW-1:0] upd_next_addr_i = '0, upd_target_addr_i = '0;

  always #4 clk = ~clk;

  jump_trace_store #(.ENTRIES(N), .ADDR_W(AW)) u0 (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Independent reference model
  logic [AW-1:0] m_key [N];
  logic [AW-1:0] m_tgt [N];
  bit            m_val [N];
  int            m_ptr;

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_key[i] = '0; m_tgt[i] = '0; end
    m_ptr = 0;
  endfunction

  function automatic void model_update(bit clr, bit v, bit tk, bit pr, bit lit,
                                       logic [AW-1:0] nxt, logic [AW-1:0] tgt);
    logic [AW-1:0] k;
    if (clr) begin
      for (int i = 0; i < N; i++) m_val[i] = 0;
      m_ptr = 0;
    end else if (v && tk && !pr && lit) begin
      k = nxt + {AW{1'b1}};
      for (int i = 0; i < N; i++) if (m_val[i] && m_key[i] == k && i != m_ptr) m_val[i] = 0;
      m_key[m_ptr] = k; m_tgt[m_ptr] = tgt; m_val[m_ptr] = 1;
      m_ptr = (m_ptr + 1) % N;
    end
  endfunction

  function automatic void model_lookup(logic [AW-1:0] a, output bit h, output logic [AW-1:0] t);
    h = 0; t = '0;
    for (int i = 0; i < N; i++) if (m_val[i] && m_key[i] == a) begin h = 1; t = m_tgt[i]; end
  endfunction

  task automatic compare(string req);
    bit eh; logic [AW-1:0] et;
    model_lookup(lk_addr_i, eh, et);
    checks++;
    if (lk_hit_o !== eh || lk_target_o !== et) begin
      fails++;
      $display("FAIL %s addr=%h: hit=%b tgt=%h expected hit=%b tgt=%h",
               req, lk_addr_i, lk_hit_o, lk_target_o, eh, et);
    end
  endtask

  // One cycle: drive at negedge, check lookup before the edge, then advance model.
  task automatic step(bit clr, bit v, bit tk, bit pr, bit lit,
                      logic [AW-1:0] nxt, logic [AW-1:0] tgt, logic [AW-1:0] la, string req);
    @(negedge clk);
    clear_i = clr; upd_valid_i = v; upd_taken_i = tk; upd_predicted_i = pr;
    upd_literal_i = lit; upd_next_addr_i = nxt; upd_target_addr_i = tgt; lk_addr_i = la;
    #2 compare(req);
    @(posedge clk);
    model_update(clr, v, tk, pr, lit, nxt, tgt);
  endtask

  task automatic look(logic [AW-1:0] la, string req);
    step(0, 0, 0, 0, 0, '0, '0, la, req);
  endtask

  task automatic train(logic [AW-1:0] nxt, logic [AW-1:0] tgt, logic [AW-1:0] la, string req);
    step(0, 1, 1, 0, 1, nxt, tgt, la, req);
  endtask

  function automatic logic [AW-1:0] pool(int k);
    return AW'(16'h0200 + k * 6);
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1457);
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    look(16'h0000, "R1"); look(pool(0) - 1, "R1"); look(16'hFFFF, "R1");

    // R4: key is fall-through minus one, including wrap at zero
    train(16'h1000, 16'hAAAA, 16'h0FFF, "R8");
    look(16'h0FFF, "R4"); look(16'h1000, "R4");
    train(16'h0000, 16'hBEEF, 16'hFFFF, "R8");
    look(16'hFFFF, "R4");

    // R8: same-cycle lookup sees old target, new one next cycle
    train(16'h1000, 16'h5555, 16'h0FFF, "R8");
    look(16'h0FFF, "R8");

    // R3 / R9: unqualified updates do nothing
    step(0, 1, 1, 1, 1, 16'h3001, 16'h1111, 16'h3000, "R9");
    step(0, 1, 0, 1, 1, 16'h0000, 16'h1111, 16'h3000, "R9");
    look(16'h3000, "R9"); look(16'hFFFF, "R9");
    step(0, 1, 1, 0, 0, 16'h3001, 16'h2222, 16'h3000, "R3");
    step(0, 1, 0, 0, 1, 16'h3001, 16'h2222, 16'h3000, "R3");
    step(0, 0, 1, 0, 1, 16'h3001, 16'h2222, 16'h3000, "R3");
    look(16'h3000, "R3");

    // R6: clear, including clear together with an update
    step(1, 1, 1, 0, 1, 16'h4001, 16'h3333, 16'h0FFF, "R6");
    look(16'h0FFF, "R6"); look(16'h4000, "R6"); look(16'hFFFF, "R6");

    // R5: fill N entries then one more, oldest evicted
    for (int i = 0; i <= N; i++) train(AW'(16'h5001 + 16'h10 * i), AW'(16'h7000 + i), 16'h5000, "R5");
    for (int i = 0; i <= N; i++) look(AW'(16'h5000 + 16'h10 * i), "R5");

    // R7: duplicate key replaces older entry
    train(16'h5021, 16'h9999, 16'h5020, "R7");
    look(16'h5020, "R7");
    train(16'h5021, 16'h8888, 16'h5020, "R7");
    look(16'h5020, "R7");

    // Random phase: R2 over many mixed patterns
    for (int n = 0; n < 3000; n++) begin
      int r;
      bit clr;
      logic [AW-1:0] la;
      r   = $urandom_range(0, 99);
      clr = (r < 2);
      la  = ($urandom_range(0, 3) != 0) ? pool($urandom_range(0, 13)) - 1 : AW'($urandom);
      step(clr, 1'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 3) != 0), pool($urandom_range(0, 13)), AW'($urandom), la, "R2");
    end

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule